// File: doc/BRIEF.md
# Load Queue Ordering Violation Detector

This block holds the in-flight loads of one thread of an out-of-order core in a circular queue and watches for memory ordering mistakes. The allocation stage places loads in program order, each tagged with a sequence number. The block returns the slot index it used, so the load can later report its executed address by that index. When a store executes, every younger load that already has an address in the same comparison granule is a violator. Addresses are compared after a configurable right shift. Cache invalidation snoops mark executed loads whose cache block matches. A later-executing load then flags a younger load only if that younger load was marked, which catches load-load reordering across a remote write.

Only the oldest violator is kept. Its sequence number stays visible until the consumer reads it out. Commit retires a run of old loads from the head in a single cycle. Squash cuts off every load younger than a given sequence number and drops a recorded violator that falls in the squashed range. Full, empty and free-slot status go back to the allocation stage. All state changes take effect at the rising clock edge, and every status output is registered.

Top module: `lq_violation_detector`

## Requirements
- R1: An accepted allocation writes the load into slot `alloc_idx` (head index plus occupancy, modulo DEPTH). After the edge, `lq_free` equals DEPTH minus the occupancy, `lq_full` is 1 exactly when the occupancy is DEPTH, and `lq_empty` is 1 exactly when the occupancy is 0. Reset leaves the queue empty with no violator.
- R2: `alloc_stall` equals `alloc_valid` while the queue is full or `squash_valid` is high. A stalled allocation changes no state.
- R3: A store execute flags every load that is live, already executed, younger than `st_exec_seq`, and whose address shifted right by DEP_SHIFT equals the store address shifted the same way. Older loads, unexecuted loads and loads in another granule are not flagged.
- R4: A load execute on a live slot flags a younger, already executed load in the same shifted granule only if that younger load carries a snoop mark.
- R5: A snoop marks each live executed load whose address ANDed with the inverse of (BLK_BYTES-1) equals the snoop address masked the same way. A load that executes again clears its own mark.
- R6: Among all violators found in one cycle, the oldest in program order is taken. It replaces the recorded violator only when none is held or it is older than the one held.
- R7: `viol_valid` stays set until a cycle with `viol_read` high. It is low after that edge unless a new violator is found in the same cycle.
- R8: With `commit_valid`, the run of loads starting at the head whose sequence numbers are not younger than `commit_seq` is retired in one cycle.
- R9: With `squash_valid`, every load younger than `squash_seq` is removed, and the recorded violator is cleared if it is younger. In that cycle allocation, execution, snoop and commit requests are ignored, but `viol_read` still acts.
- R10: Sequence number A is younger than B when (A-B) modulo 2^SEQ_W is nonzero and its top bit is 0, so order survives counter wraparound.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc_valid | input | 1 | Allocate a load |
| alloc_seq | input | SEQ_W | Sequence number of the allocated load |
| alloc_stall | output | 1 | Allocation refused this cycle |
| alloc_idx | output | log2(DEPTH) | Slot the next allocation uses |
| ld_exec_valid | input | 1 | A load reports its executed address |
| ld_exec_idx | input | log2(DEPTH) | Slot of the executing load |
| ld_exec_addr | input | ADDR_W | Executed load address |
| st_exec_valid | input | 1 | A store executes |
| st_exec_seq | input | SEQ_W | Sequence number of the store |
| st_exec_addr | input | ADDR_W | Store address |
| snoop_valid | input | 1 | Incoming invalidation snoop |
| snoop_addr | input | ADDR_W | Snooped address |
| commit_valid | input | 1 | Retire old loads |
| commit_seq | input | SEQ_W | Youngest sequence number allowed to retire |
| squash_valid | input | 1 | Flush younger loads |
| squash_seq | input | SEQ_W | Loads younger than this are removed |
| viol_read | input | 1 | Consume the recorded violator |
| viol_valid | output | 1 | A violator is recorded |
| viol_seq | output | SEQ_W | Sequence number of the recorded violator |
| lq_full | output | 1 | Queue full |
| lq_empty | output | 1 | Queue empty |
| lq_free | output | log2(DEPTH)+1 | Number of free slots |

## Verification
Properties check on every cycle that occupancy stays in range, that a refused allocation leaves the free count unchanged, and that a recorded violator persists until it is read. They also check that a recorded violator can only be replaced by an older one and that the chosen violator is really one of the flagged slots. Which loads get flagged, the snoop-then-load sequence that exposes load-load reordering, the length of a multi-load commit, and squash boundaries across sequence wraparound depend on the history of addresses and ages. Only the bench's directed and random scenarios, run against its reference queue model, can show these.

// File: rtl/lqv_pkg.sv
`timescale 1ns/1ps
package lqv_pkg;
  parameter int SEQ_W = 8;
  typedef logic [SEQ_W-1:0] seq_t;

  // a is younger than b when the modular distance is positive and below half range
  function automatic logic seq_younger(input seq_t a, input seq_t b);
    seq_t d;
    d = a - b;
    return (d != '0) && !d[SEQ_W-1];
  endfunction
endpackage

// File: rtl/lqv_match.sv
`timescale 1ns/1ps
module lqv_match
  import lqv_pkg::*;
#(
  parameter int DEPTH     = 8,
  parameter int ADDR_W    = 16,
  parameter int DEP_SHIFT = 3,
  parameter int BLK_BYTES = 16
) (
  input  logic [DEPTH-1:0]  live,
  input  logic [DEPTH-1:0]  exec,
  input  logic [DEPTH-1:0]  snp,
  input  seq_t              ent_seq  [DEPTH],
  input  logic [ADDR_W-1:0] ent_addr [DEPTH],
  input  logic              st_go,
  input  seq_t              st_seq,
  input  logic [ADDR_W-1:0] st_addr,
  input  logic              ld_go,
  input  seq_t              ld_seq,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic              snp_go,
  input  logic [ADDR_W-1:0] snp_addr,
  output logic [DEPTH-1:0]  vio_hit,
  output logic [DEPTH-1:0]  snp_hit
);
  localparam logic [ADDR_W-1:0] BLK_MASK = ~ADDR_W'(BLK_BYTES - 1);

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    logic gran_st, gran_ld, blk_eq;
    if (DEP_SHIFT == 0) begin : g_full
      assign gran_st = ent_addr[i] == st_addr;
      assign gran_ld = ent_addr[i] == ld_addr;
    end else begin : g_coarse
      assign gran_st = (ent_addr[i] >> DEP_SHIFT) == (st_addr >> DEP_SHIFT);
      assign gran_ld = (ent_addr[i] >> DEP_SHIFT) == (ld_addr >> DEP_SHIFT);
    end
    assign blk_eq = (ent_addr[i] & BLK_MASK) == (snp_addr & BLK_MASK);

    assign vio_hit[i] = live[i] & exec[i] &
                        ((st_go & seq_younger(ent_seq[i], st_seq) & gran_st) |
                         (ld_go & snp[i] & seq_younger(ent_seq[i], ld_seq) & gran_ld));
    assign snp_hit[i] = snp_go & live[i] & exec[i] & blk_eq;
  end
endmodule

// File: rtl/lqv_pick.sv
`timescale 1ns/1ps
module lqv_pick #(
  parameter int DEPTH = 8,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic [DEPTH-1:0] req,
  input  logic [PTR_W-1:0] head,
  output logic             found,
  output logic [PTR_W-1:0] idx
);
  // first requester in program order, scanning from the head
  always_comb begin
    logic [PTR_W-1:0] p;
    p     = '0;
    found = 1'b0;
    idx   = head;
    for (int k = DEPTH - 1; k >= 0; k--) begin
      p = head + PTR_W'(k);
      if (req[p]) begin
        found = 1'b1;
        idx   = p;
      end
    end
  end
endmodule

// File: rtl/lq_violation_detector.sv
`timescale 1ns/1ps
module lq_violation_detector
  import lqv_pkg::*;
#(
  parameter int DEPTH     = 8,
  parameter int ADDR_W    = 16,
  parameter int DEP_SHIFT = 3,
  parameter int BLK_BYTES = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        alloc_valid,
  input  logic [lqv_pkg::SEQ_W-1:0]   alloc_seq,
  output logic                        alloc_stall,
  output logic [$clog2(DEPTH)-1:0]    alloc_idx,
  input  logic                        ld_exec_valid,
  input  logic [$clog2(DEPTH)-1:0]    ld_exec_idx,
  input  logic [ADDR_W-1:0]           ld_exec_addr,
  input  logic                        st_exec_valid,
  input  logic [lqv_pkg::SEQ_W-1:0]   st_exec_seq,
  input  logic [ADDR_W-1:0]           st_exec_addr,
  input  logic                        snoop_valid,
  input  logic [ADDR_W-1:0]           snoop_addr,
  input  logic                        commit_valid,
  input  logic [lqv_pkg::SEQ_W-1:0]   commit_seq,
  input  logic                        squash_valid,
  input  logic [lqv_pkg::SEQ_W-1:0]   squash_seq,
  input  logic                        viol_read,
  output logic                        viol_valid,
  output logic [lqv_pkg::SEQ_W-1:0]   viol_seq,
  output logic                        lq_full,
  output logic                        lq_empty,
  output logic [$clog2(DEPTH):0]      lq_free
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = PTR_W + 1;

  seq_t              seq_q  [DEPTH];
  seq_t              seq_d  [DEPTH];
  logic [ADDR_W-1:0] addr_q [DEPTH];
  logic [ADDR_W-1:0] addr_d [DEPTH];
  logic [DEPTH-1:0]  exec_q, exec_d, snp_q, snp_d;
  logic [PTR_W-1:0]  head_q, head_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              vv_q, vv_d;
  seq_t              vs_q, vs_d;

  logic [DEPTH-1:0]  live, vio_hit, snp_hit;
  logic [PTR_W-1:0]  tail, pick_idx;
  logic              pick_found, is_full, quiet;
  logic              ld_go, st_go, snp_go, alloc_go;
  logic [CNT_W-1:0]  ret_cnt, keep_cnt;
  seq_t              cand_seq;

  always_comb begin
    logic [PTR_W-1:0] off;
    off = '0;
    for (int i = 0; i < DEPTH; i++) begin
      off     = PTR_W'(i) - head_q;
      live[i] = {1'b0, off} < cnt_q;
    end
  end

  assign tail     = head_q + cnt_q[PTR_W-1:0];
  assign is_full  = cnt_q == CNT_W'(DEPTH);
  assign quiet    = ~squash_valid;
  assign ld_go    = quiet & ld_exec_valid & live[ld_exec_idx];
  assign st_go    = quiet & st_exec_valid;
  assign snp_go   = quiet & snoop_valid;
  assign alloc_go = quiet & alloc_valid & ~is_full;

  lqv_match #(
    .DEPTH(DEPTH), .ADDR_W(ADDR_W), .DEP_SHIFT(DEP_SHIFT), .BLK_BYTES(BLK_BYTES)
  ) u_match (
    .live(live), .exec(exec_q), .snp(snp_q), .ent_seq(seq_q), .ent_addr(addr_q),
    .st_go(st_go), .st_seq(st_exec_seq), .st_addr(st_exec_addr),
    .ld_go(ld_go), .ld_seq(seq_q[ld_exec_idx]), .ld_addr(ld_exec_addr),
    .snp_go(snp_go), .snp_addr(snoop_addr),
    .vio_hit(vio_hit), .snp_hit(snp_hit)
  );

  lqv_pick #(.DEPTH(DEPTH)) u_pick (
    .req(vio_hit), .head(head_q), .found(pick_found), .idx(pick_idx)
  );

  assign cand_seq = seq_q[pick_idx];

  // commit: length of the old run starting at the head
  always_comb begin
    logic run;
    logic [PTR_W-1:0] p;
    run     = commit_valid & quiet;
    p       = '0;
    ret_cnt = '0;
    for (int k = 0; k < DEPTH; k++) begin
      p = head_q + PTR_W'(k);
      if (run && (CNT_W'(k) < cnt_q) && !seq_younger(seq_q[p], commit_seq))
        ret_cnt = ret_cnt + CNT_W'(1);
      else
        run = 1'b0;
    end
  end

  // squash: live entries not younger than the squash point survive
  always_comb begin
    keep_cnt = '0;
    for (int i = 0; i < DEPTH; i++)
      if (live[i] && !seq_younger(seq_q[i], squash_seq))
        keep_cnt = keep_cnt + CNT_W'(1);
  end

  always_comb begin
    logic base;
    seq_d  = seq_q;
    addr_d = addr_q;
    exec_d = exec_q;
    snp_d  = snp_q | snp_hit;
    if (ld_go) begin
      addr_d[ld_exec_idx] = ld_exec_addr;
      exec_d[ld_exec_idx] = 1'b1;
      snp_d[ld_exec_idx]  = 1'b0;
    end
    if (alloc_go) begin
      seq_d[tail]  = alloc_seq;
      exec_d[tail] = 1'b0;
      snp_d[tail]  = 1'b0;
    end
    if (squash_valid) begin
      head_d = head_q;
      cnt_d  = keep_cnt;
    end else begin
      head_d = head_q + ret_cnt[PTR_W-1:0];
      cnt_d  = cnt_q - ret_cnt + CNT_W'(alloc_go);
    end
    base = vv_q & ~viol_read;
    if (squash_valid && seq_younger(vs_q, squash_seq))
      base = 1'b0;
    vv_d = base;
    vs_d = vs_q;
    if (pick_found && (!base || seq_younger(vs_q, cand_seq))) begin
      vv_d = 1'b1;
      vs_d = cand_seq;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      cnt_q  <= '0;
      vv_q   <= 1'b0;
      vs_q   <= '0;
      exec_q <= '0;
      snp_q  <= '0;
    end else begin
      head_q <= head_d;
      cnt_q  <= cnt_d;
      vv_q   <= vv_d;
      vs_q   <= vs_d;
      exec_q <= exec_d;
      snp_q  <= snp_d;
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (alloc_go && tail == PTR_W'(i)) seq_q[i] <= seq_d[i];
      if (ld_go && ld_exec_idx == PTR_W'(i)) addr_q[i] <= addr_d[i];
    end
  end

  assign alloc_stall = alloc_valid & (is_full | squash_valid);
  assign alloc_idx   = tail;
  assign viol_valid  = vv_q;
  assign viol_seq    = vs_q;
  assign lq_full     = is_full;
  assign lq_empty    = cnt_q == '0;
  assign lq_free     = CNT_W'(DEPTH) - cnt_q;

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(DEPTH)); // R1
  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_stall && !commit_valid && !squash_valid |=> $stable(lq_free)); // R2
  AST_PICK_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    pick_found |-> vio_hit[pick_idx]); // R6
  AST_VIOL_OLDER: assert property (@(posedge clk) disable iff (!rst_n)
    vv_q && !viol_read && !squash_valid |=> !seq_younger(vs_q, $past(vs_q))); // R6
  AST_VIOL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    vv_q && !viol_read && !squash_valid |=> vv_q); // R7
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    viol_read && !pick_found |=> !vv_q); // R7
  AST_SQUASH_SHRINK: assert property (@(posedge clk) disable iff (!rst_n)
    squash_valid |=> lq_free >= $past(lq_free)); // R9
endmodule

// File: tb/sim_lq_violation_detector.sv
`timescale 1ns/1ps
module sim_lq_violation_detector;
  import lqv_pkg::*;
  localparam int DEPTH = 8;
  localparam int AW    = 16;

  logic clk, rst_n;
  logic alloc_valid, alloc_stall, ld_exec_valid, st_exec_valid, snoop_valid;
  logic commit_valid, squash_valid, viol_read, viol_valid, lq_full, lq_empty;
  logic [2:0] alloc_idx, ld_exec_idx;
  logic [3:0] lq_free;
  logic [AW-1:0] ld_exec_addr, st_exec_addr, snoop_addr;
  seq_t alloc_seq, st_exec_seq, commit_seq, squash_seq, viol_seq;

  lq_violation_detector #(.DEPTH(DEPTH), .ADDR_W(AW), .DEP_SHIFT(3), .BLK_BYTES(16)) u0 (
    .clk(clk), .rst_n(rst_n), .alloc_valid(alloc_valid), .alloc_seq(alloc_seq),
    .alloc_stall(alloc_stall), .alloc_idx(alloc_idx), .ld_exec_valid(ld_exec_valid),
    .ld_exec_idx(ld_exec_idx), .ld_exec_addr(ld_exec_addr), .st_exec_valid(st_exec_valid),
    .st_exec_seq(st_exec_seq), .st_exec_addr(st_exec_addr), .snoop_valid(snoop_valid),
    .snoop_addr(snoop_addr), .commit_valid(commit_valid), .commit_seq(commit_seq),
    .squash_valid(squash_valid), .squash_seq(squash_seq), .viol_read(viol_read),
    .viol_valid(viol_valid), .viol_seq(viol_seq), .lq_full(lq_full),
    .lq_empty(lq_empty), .lq_free(lq_free)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int checks = 0, fails = 0;
  bit done = 0;

  // reference model
  seq_t m_seq [DEPTH];
  logic [AW-1:0] m_addr [DEPTH];
  bit m_ex [DEPTH];
  bit m_sn [DEPTH];
  int m_head = 0, m_cnt = 0;
  bit m_vv = 0;
  seq_t m_vs = 0;
  seq_t next_seq = 0;

  // stimulus
  bit s_av, s_ldv, s_stv, s_snv, s_cv, s_sqv, s_rd;
  int s_ldi;
  logic [AW-1:0] s_lda, s_sta, s_sna;
  seq_t s_sts, s_cs, s_sqs;

  function automatic bit yng(seq_t a, seq_t b);
    seq_t d;
    d = a - b;
    return (d != 0) && !d[SEQ_W-1];
  endfunction

  function automatic bit mlive(int i);
    return ((i - m_head + DEPTH) % DEPTH) < m_cnt;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cmp_all();
    chk("R1 lq_free", lq_free, DEPTH - m_cnt);
    chk("R1 lq_full", lq_full, m_cnt == DEPTH);
    chk("R1 lq_empty", lq_empty, m_cnt == 0);
    chk("R1 alloc_idx", alloc_idx, (m_head + m_cnt) % DEPTH);
    chk("R7 viol_valid", viol_valid, m_vv);
    if (m_vv) chk("R6 R10 viol_seq", viol_seq, m_vs);
  endtask

  task automatic clr();
    s_av = 0; s_ldv = 0; s_stv = 0; s_snv = 0; s_cv = 0; s_sqv = 0; s_rd = 0;
    s_ldi = 0; s_lda = 0; s_sta = 0; s_sna = 0; s_sts = 0; s_cs = 0; s_sqs = 0;
  endtask

  task automatic step();
    int keep, ret, ti;
    bit found, base, ldgo, run;
    seq_t cseq;
    alloc_valid = s_av; alloc_seq = next_seq;
    ld_exec_valid = s_ldv; ld_exec_idx = 3'(s_ldi); ld_exec_addr = s_lda;
    st_exec_valid = s_stv; st_exec_seq = s_sts; st_exec_addr = s_sta;
    snoop_valid = s_snv; snoop_addr = s_sna;
    commit_valid = s_cv; commit_seq = s_cs;
    squash_valid = s_sqv; squash_seq = s_sqs; viol_read = s_rd;
    #1;
    chk("R2 alloc_stall", alloc_stall, s_av && (m_cnt == DEPTH || s_sqv));
    if (s_sqv) begin
      keep = 0;
      for (int i = 0; i < DEPTH; i++)
        if (mlive(i) && !yng(m_seq[i], s_sqs)) keep++;
      m_cnt = keep;
      if (s_rd || (m_vv && yng(m_vs, s_sqs))) m_vv = 0;
      next_seq = s_sqs + 1;
    end else begin
      ldgo = s_ldv && mlive(s_ldi);
      found = 0; cseq = 0;
      for (int k = 0; k < m_cnt; k++) begin
        ti = (m_head + k) % DEPTH;
        if (!found && m_ex[ti] &&
            ((s_stv && yng(m_seq[ti], s_sts) && (m_addr[ti] >> 3) == (s_sta >> 3)) ||
             (ldgo && m_sn[ti] && yng(m_seq[ti], m_seq[s_ldi]) && (m_addr[ti] >> 3) == (s_lda >> 3)))) begin
          found = 1; cseq = m_seq[ti];
        end
      end
      base = m_vv && !s_rd;
      if (found && (!base || yng(m_vs, cseq))) begin m_vv = 1; m_vs = cseq; end
      else m_vv = base;
      if (s_snv)
        for (int i = 0; i < DEPTH; i++)
          if (mlive(i) && m_ex[i] && (m_addr[i] & ~16'hF) == (s_sna & ~16'hF)) m_sn[i] = 1;
      if (ldgo) begin m_addr[s_ldi] = s_lda; m_ex[s_ldi] = 1; m_sn[s_ldi] = 0; end
      ret = 0; run = s_cv;
      for (int k = 0; k < m_cnt; k++) begin
        if (run && !yng(m_seq[(m_head + k) % DEPTH], s_cs)) ret++;
        else run = 0;
      end
      if (s_av && m_cnt < DEPTH) begin
        ti = (m_head + m_cnt) % DEPTH;
        m_seq[ti] = next_seq; m_ex[ti] = 0; m_sn[ti] = 0;
        next_seq++;
        m_cnt++;
      end
      m_head = (m_head + ret) % DEPTH;
      m_cnt = m_cnt - ret;
    end
    @(negedge clk);
    cmp_all();
  endtask

  function automatic logic [AW-1:0] pool_addr();
    return 16'h0400 + 16'(($urandom % 16) * 4);
  endfunction

  initial begin
    #(8 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < DEPTH; i++) begin m_ex[i] = 0; m_sn[i] = 0; m_seq[i] = 0; m_addr[i] = 0; end
    clr();
    rst_n = 0;
    alloc_valid = 0; alloc_seq = 0; ld_exec_valid = 0; ld_exec_idx = 0; ld_exec_addr = 0;
    st_exec_valid = 0; st_exec_seq = 0; st_exec_addr = 0; snoop_valid = 0; snoop_addr = 0;
    commit_valid = 0; commit_seq = 0; squash_valid = 0; squash_seq = 0; viol_read = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 reset empty", lq_empty, 1);
    chk("R1 reset free", lq_free, 8);
    chk("R7 reset no violator", viol_valid, 0);

    // fill, then refused allocation
    clr(); s_av = 1;
    repeat (8) step();
    step();
    chk("R2 full refuse keeps free", lq_free, 0);

    // store against younger executed loads in one granule
    clr(); s_ldv = 1; s_ldi = 5; s_lda = 16'h0408; step();
    s_ldi = 6; s_lda = 16'h040C; step();
    clr(); s_stv = 1; s_sts = 4; s_sta = 16'h040F; step();
    chk("R3 store flags younger load", viol_valid, 1);
    chk("R6 oldest of two picked", viol_seq, 5);
    clr(); s_rd = 1; step();
    chk("R7 read clears", viol_valid, 0);
    clr(); s_stv = 1; s_sts = 6; s_sta = 16'h0408; step();
    chk("R3 older or unexecuted not flagged", viol_valid, 0);
    s_sts = 4; s_sta = 16'h0410; step();
    chk("R3 other granule not flagged", viol_valid, 0);

    // load-load with and without snoop mark
    clr(); s_ldv = 1; s_ldi = 7; s_lda = 16'h0420; step();
    s_ldi = 2; s_lda = 16'h0420; step();
    chk("R4 unmarked younger load not flagged", viol_valid, 0);
    clr(); s_snv = 1; s_sna = 16'h042C; step();
    clr(); s_ldv = 1; s_ldi = 3; s_lda = 16'h0424; step();
    chk("R4 marked younger load flagged", viol_valid, 1);
    chk("R5 block match marked seq 7", viol_seq, 7);
    clr(); s_stv = 1; s_sts = 4; s_sta = 16'h040F; step();
    chk("R6 older violator replaces", viol_seq, 5);
    s_sts = 5; s_sta = 16'h040C; step();
    chk("R6 younger violator ignored", viol_seq, 5);

    // commit and squash
    clr(); s_cv = 1; s_cs = 2; step();
    chk("R8 three loads retired", lq_free, 3);
    clr(); s_sqv = 1; s_sqs = 4; s_av = 1; step();
    chk("R9 squash frees younger", lq_free, 6);
    chk("R9 squashed violator dropped", viol_valid, 0);

    // random phase; many allocations wrap the sequence counter (R10)
    for (int n = 0; n < 4000; n++) begin
      clr();
      s_av  = ($urandom % 3) != 0;
      s_ldv = ($urandom % 2) != 0; s_ldi = $urandom % DEPTH; s_lda = pool_addr();
      s_stv = ($urandom % 4) == 0; s_sta = pool_addr();
      s_sts = (m_cnt > 0) ? m_seq[(m_head + ($urandom % m_cnt)) % DEPTH] - seq_t'($urandom % 2) : next_seq;
      s_snv = ($urandom % 5) == 0; s_sna = pool_addr();
      s_cv  = ($urandom % 3) == 0;
      s_cs  = (m_cnt > 0) ? m_seq[m_head] + seq_t'($urandom % 3) - seq_t'(1) : next_seq;
      s_rd  = ($urandom % 4) == 0;
      s_sqv = (m_cnt > 0) && (($urandom % 20) == 0);
      if (s_sqv)
        s_sqs = (($urandom % 4) == 0) ? m_seq[m_head] - seq_t'(1)
                                      : m_seq[(m_head + ($urandom % m_cnt)) % DEPTH];
      step();
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule